// File: doc/BRIEF.md
# ATM Cell VPI Filter with Loopback

This block sits on the receive side of a byte-wide ATM cell interface. Cells arrive one byte per cycle as 53-byte units. The first byte of each cell carries a start flag, and every byte has an odd-parity bit. From the first two bytes the block rebuilds the 12-bit virtual path identifier, GFC nibble included. It compares that value with a programmable match value, bit by bit, under an enable mask. Each cell is then kept or discarded as a whole. Kept cells go into a receive buffer and leave on the `rx_*` stream, always as complete cells.

Every received byte is checked for parity, and bytes that fail are counted in a 16-bit counter. When that counter wraps, a sticky flag is set. In loopback mode, kept cells do not leave on the `rx_*` stream. They move from the receive buffer into a transmit buffer and leave on the `out_*` stream. Software uses a small register port to set the match value, the mask and the control bits, and to read the counter and the flag.

Top module: `vpi_cell_filter`

## Requirements
- R1: The match register (address 0) and the enable register (address 1) each hold 12 bits. Bits 15:12 read back as zero after any write.
- R2: A VPI bit whose enable bit is 0 always counts as matching. A cell is kept only if every enabled bit of its VPI equals the same bit of the match value.
- R3: The VPI is {byte0[7:0], byte1[7:4]}. A kept cell leaves on `rx_*` as all 53 bytes in order, with `rx_sof` high on the first byte only. A rejected cell produces no output byte at all.
- R4: When enable bits 11:8 are cleared, the GFC nibble (byte0[7:4]) has no effect on the decision. When those bits are set, the GFC is compared.
- R5: Each byte taken on the input with an even count of ones across `in_data` and `in_par` increments the counter at address 2. A write to address 2 clears the counter.
- R6: When the counter wraps from 0xFFFF to 0, bit 0 of the status register (address 4) is set. It stays set until software writes 1 to that bit. It is not set before the wrap.
- R7: While control bit 0 at address 3 is set, kept cells leave on `out_*` with the same bytes and framing, and `rx_valid` stays low. Rejected cells produce no `out_*` byte.
- R8: After reset, all registers read 0, `in_ready` is 1, and `rx_valid` and `out_valid` are 0. With the mask cleared, every cell is kept.
- R9: Writing 1 to control bit 2 empties the receive buffer, and writing 1 to control bit 1 empties the transmit buffer. Both bits clear themselves and read back as 0.
- R10: Each buffer holds at least two whole cells. Between cells, `in_ready` is low whenever fewer than 53 bytes of receive-buffer space remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_sof | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| in_par | input | 1 | Odd-parity bit for in_data |
| rx_valid | output | 1 | Receive stream byte present |
| rx_ready | input | 1 | Receive stream consumer ready |
| rx_sof | output | 1 | First byte of a receive-stream cell |
| rx_data | output | 8 | Receive stream byte |
| out_valid | output | 1 | Loopback stream byte present |
| out_ready | input | 1 | Loopback stream consumer ready |
| out_sof | output | 1 | First byte of a loopback cell |
| out_data | output | 8 | Loopback stream byte |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
A table of cells is sent through the filter. Each entry pairs a VPI with a match value and a mask, and together the entries cover the following cases:
- exact equality;
- a difference that the mask hides;
- a difference that the mask exposes, in low bits and in the top bit;
- a GFC-only difference, with the GFC compared and with it excluded.

Each entry tells whether the masked compare looks at the right bits of the right bytes. Further cells check the following:
- bad-parity bytes, including a 65536-byte run that must wrap the counter at exactly the right byte;
- loopback of a kept cell and of a rejected cell;
- emptying each buffer while a cell is waiting in it;
- two cells held back, to show that the input stalls once space for a third cell is gone.

// File: rtl/vf_pkg.sv
`timescale 1ns/1ps
package vf_pkg;
    localparam int CELL_BYTES = 53;
    localparam int VPI_W      = 12;
    localparam int REG_W      = 16;

    typedef struct packed {
        logic       sof;
        logic [7:0] data;
    } cbyte_t;

    typedef enum logic [2:0] {
        RA_MATCH  = 3'd0,
        RA_ENABLE = 3'd1,
        RA_PARCNT = 3'd2,
        RA_CTRL   = 3'd3,
        RA_STATUS = 3'd4
    } reg_addr_e;

    // odd parity: total ones across data and parity bit must be odd
    function automatic logic parity_bad(input logic [7:0] d, input logic p);
        return ~(^{d, p});
    endfunction

    function automatic logic [VPI_W-1:0] cell_vpi(input logic [7:0] b0, input logic [7:0] b1);
        return {b0, b1[7:4]};
    endfunction

    function automatic logic vpi_accept(input logic [VPI_W-1:0] vpi,
                                        input logic [VPI_W-1:0] match,
                                        input logic [VPI_W-1:0] en);
        return ((vpi ^ match) & en) == '0;
    endfunction
endpackage

// File: rtl/vf_fifo.sv
`timescale 1ns/1ps
module vf_fifo
    import vf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  cbyte_t        wr_data,
    input  logic          commit,
    input  logic          rewind,
    input  logic          rd_en,
    output cbyte_t        rd_data,
    output logic          rd_avail,
    output logic [$clog2(DEPTH):0] free_cnt
);
    localparam int AW = $clog2(DEPTH);

    cbyte_t      mem [DEPTH];
    logic [AW:0] wr_p, cm_p, rd_p, base, used;

    // rewind drops the uncommitted bytes of the current cell
    always_comb begin
        base     = rewind ? cm_p : wr_p;
        used     = wr_p - rd_p;
        free_cnt = (AW+1)'(DEPTH) - used;
        rd_avail = (cm_p != rd_p);
        rd_data  = mem[rd_p[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_p <= '0;
            cm_p <= '0;
            rd_p <= '0;
        end else begin
            wr_p <= base + (AW+1)'(wr_en);
            if (commit) cm_p <= base + (AW+1)'(wr_en);
            if (rd_en)  rd_p <= rd_p + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[base[AW-1:0]] <= wr_data;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |-> ((base - rd_p) < (AW+1)'(DEPTH)));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_avail);
endmodule

// File: rtl/vf_regs.sv
`timescale 1ns/1ps
module vf_regs
    import vf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       addr,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             par_err,
    output logic [VPI_W-1:0] match,
    output logic [VPI_W-1:0] enable,
    output logic             loopback,
    output logic             flush_in,
    output logic             flush_out
);
    logic [CNT_W-1:0] par_cnt;
    logic             roll_sticky;
    logic             wr_match, wr_en_reg, wr_cnt, wr_ctrl, wr_stat;

    always_comb begin
        wr_match  = wr && (addr == RA_MATCH);
        wr_en_reg = wr && (addr == RA_ENABLE);
        wr_cnt    = wr && (addr == RA_PARCNT);
        wr_ctrl   = wr && (addr == RA_CTRL);
        wr_stat   = wr && (addr == RA_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match       <= '0;
            enable      <= '0;
            loopback    <= 1'b0;
            flush_in    <= 1'b0;
            flush_out   <= 1'b0;
            par_cnt     <= '0;
            roll_sticky <= 1'b0;
        end else begin
            if (wr_match)  match  <= wdata[VPI_W-1:0];
            if (wr_en_reg) enable <= wdata[VPI_W-1:0];
            if (wr_ctrl)   loopback <= wdata[0];
            flush_out <= wr_ctrl && wdata[1];
            flush_in  <= wr_ctrl && wdata[2];
            if (wr_cnt)       par_cnt <= '0;
            else if (par_err) par_cnt <= par_cnt + 1'b1;
            if (par_err && !wr_cnt && (par_cnt == '1)) roll_sticky <= 1'b1;
            else if (wr_stat && wdata[0])              roll_sticky <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_MATCH:  rdata[VPI_W-1:0] = match;
            RA_ENABLE: rdata[VPI_W-1:0] = enable;
            RA_PARCNT: rdata[CNT_W-1:0] = par_cnt;
            RA_CTRL:   rdata[0]         = loopback;
            RA_STATUS: rdata[0]         = roll_sticky;
            default:   rdata            = '0;
        endcase
    end

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (roll_sticky && !(wr_stat && wdata[0])) |=> roll_sticky);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (par_cnt == $past(par_cnt) || par_cnt == $past(par_cnt) + 1'b1));
endmodule

// File: rtl/vpi_cell_filter.sv
`timescale 1ns/1ps
module vpi_cell_filter
    import vf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sof,
    input  logic [7:0]  in_data,
    input  logic        in_par,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic        rx_sof,
    output logic [7:0]  rx_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_sof,
    output logic [7:0]  out_data,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);
    localparam int AW    = $clog2(DEPTH);
    localparam int IDX_W = $clog2(CELL_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    logic [VPI_W-1:0] match, enable;
    logic             loopback, flush_in, flush_out;
    logic             take, in_cell, drop_q, reject_now;
    logic [IDX_W-1:0] idx;
    logic [7:0]       b0_q;
    logic             in_wr, in_commit, in_rewind, in_rd, in_avail;
    logic             out_rd, out_avail, xfer;
    cbyte_t           in_q, out_q;
    logic [AW:0]      in_free, out_free;

    vf_regs i_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .par_err(take && parity_bad(in_data, in_par)),
        .match(match), .enable(enable), .loopback(loopback),
        .flush_in(flush_in), .flush_out(flush_out)
    );

    // space for a full cell is reserved before its first byte is taken
    assign in_ready   = in_cell || (in_free >= (AW+1)'(CELL_BYTES));
    assign take       = in_valid && in_ready;
    assign reject_now = !vpi_accept(cell_vpi(b0_q, in_data), match, enable);

    always_comb begin
        in_wr     = 1'b0;
        in_commit = 1'b0;
        in_rewind = 1'b0;
        if (take) begin
            if (in_sof) begin
                in_wr     = 1'b1;
                in_rewind = in_cell;
            end else if (in_cell && !drop_q) begin
                if (idx == IDX_W'(1) && reject_now) begin
                    in_rewind = 1'b1;
                end else begin
                    in_wr     = 1'b1;
                    in_commit = (idx == LAST_IDX);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_in) begin
            in_cell <= 1'b0;
            idx     <= '0;
            drop_q  <= 1'b0;
            b0_q    <= '0;
        end else if (take) begin
            if (in_sof) begin
                in_cell <= 1'b1;
                idx     <= IDX_W'(1);
                drop_q  <= 1'b0;
                b0_q    <= in_data;
            end else if (in_cell) begin
                idx <= idx + 1'b1;
                if (idx == IDX_W'(1) && reject_now) drop_q <= 1'b1;
                if (idx == LAST_IDX) in_cell <= 1'b0;
            end
        end
    end

    vf_fifo #(.DEPTH(DEPTH)) i_in_fifo (
        .clk(clk), .rst(rst), .flush(flush_in),
        .wr_en(in_wr), .wr_data('{sof: in_sof, data: in_data}),
        .commit(in_commit), .rewind(in_rewind),
        .rd_en(in_rd), .rd_data(in_q), .rd_avail(in_avail), .free_cnt(in_free)
    );

    assign xfer     = loopback && in_avail && (out_free != '0);
    assign in_rd    = loopback ? xfer : (rx_ready && in_avail);
    assign rx_valid = !loopback && in_avail;
    assign rx_sof   = in_q.sof;
    assign rx_data  = in_q.data;

    vf_fifo #(.DEPTH(DEPTH)) i_out_fifo (
        .clk(clk), .rst(rst), .flush(flush_out),
        .wr_en(xfer), .wr_data(in_q), .commit(1'b1), .rewind(1'b0),
        .rd_en(out_rd), .rd_data(out_q), .rd_avail(out_avail), .free_cnt(out_free)
    );

    assign out_rd    = out_ready && out_avail;
    assign out_valid = out_avail;
    assign out_sof   = out_q.sof;
    assign out_data  = out_q.data;

    // R7
    out_start_lb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(loopback));

    // R2
    drop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_q && in_cell && !(take && in_sof) && !flush_in) |=> drop_q);
endmodule

// File: tb/test_vpi_cell_filter.sv
`timescale 1ns/1ps
module test_vpi_cell_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_sof = 0, in_par = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready;
    logic        rx_valid, rx_sof, out_valid, out_sof;
    logic        rx_ready = 1, out_ready = 1;
    logic [7:0]  rx_data, out_data;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;

    int checks = 0, fails = 0;
    int rx_n = 0, out_n = 0, rx_err = 0, out_err = 0, rx_pos = 0, out_pos = 0;
    logic [11:0] cur_vpi = 0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    vpi_cell_filter i_vpi_cell_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_data(in_data), .in_par(in_par), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_sof(rx_sof), .rx_data(rx_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sof(out_sof), .out_data(out_data), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] exp_byte(int pos);
        if (pos == 0) return cur_vpi[11:4];
        if (pos == 1) return {cur_vpi[3:0], 4'h5};
        return 8'(pos);
    endfunction

    // stream monitors, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && rx_valid && rx_ready) begin
            if (rx_sof) rx_pos = 0;
            if ((rx_pos == 0) != rx_sof || rx_data != exp_byte(rx_pos)) rx_err++;
            rx_pos++; rx_n++;
        end
        if (!rst && out_valid && out_ready) begin
            if (out_sof) out_pos = 0;
            if ((out_pos == 0) != out_sof || out_data != exp_byte(out_pos)) out_err++;
            out_pos++; out_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk);
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic send_cell(input logic [11:0] vpi, input int nbad);
        cur_vpi = vpi;
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0);
            in_data  = (i == 0) ? vpi[11:4] : (i == 1) ? {vpi[3:0], 4'h5} : 8'(i);
            in_par   = (i >= 5 && i < 5 + nbad) ? ^in_data : ~^in_data;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); in_valid = 0; in_sof = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // {vpi, match, enable, keep}
    localparam logic [36:0] VEC [9] = '{
        {12'h123, 12'h000, 12'h000, 1'b1},   // R8 mask clear keeps all
        {12'h123, 12'h123, 12'hFFF, 1'b1},   // R3 exact
        {12'h124, 12'h123, 12'hFFF, 1'b0},   // R3 low bits differ
        {12'h124, 12'h123, 12'hFF8, 1'b1},   // R2 difference hidden
        {12'h124, 12'h123, 12'hFFC, 1'b0},   // R2 bit 2 exposed
        {12'hA55, 12'h355, 12'h0FF, 1'b1},   // R4 GFC excluded
        {12'hA55, 12'h355, 12'hFFF, 1'b0},   // R4 GFC compared
        {12'h800, 12'h000, 12'h800, 1'b0},   // R2 top bit
        {12'hFFF, 12'hFFF, 12'h0FF, 1'b1}    // R2 all ones
    };

    initial begin
        #(8 * 190000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R8 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), rv); chk("R8 register reset", rv, 0);
        end
        chk("R8 in_ready", in_ready, 1);
        chk("R8 rx_valid", rx_valid, 0);
        chk("R8 out_valid", out_valid, 0);

        // R1 width
        wr(3'd0, 16'hFFFF); rd(3'd0, rv); chk("R1 match width", rv, 16'h0FFF);
        wr(3'd1, 16'hFFFF); rd(3'd1, rv); chk("R1 enable width", rv, 16'h0FFF);

        // vector table
        for (int v = 0; v < 9; v++) begin
            wr(3'd0, {4'h0, VEC[v][24:13]});
            wr(3'd1, {4'h0, VEC[v][12:1]});
            rx_n = 0;
            send_cell(VEC[v][36:25], 0);
            wait_cyc(80);
            chk($sformatf("R2/R3/R4 vector %0d byte count", v), rx_n, VEC[v][0] ? 53 : 0);
        end
        chk("R3 cell content and framing", rx_err, 0);

        // R5 parity counting and clear
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
        send_cell(12'h321, 3); wait_cyc(80);
        rd(3'd2, rv); chk("R5 bad byte count", rv, 3);
        wr(3'd2, 16'h0000); rd(3'd2, rv); chk("R5 write clears", rv, 0);

        // R6 rollover
        @(negedge clk); in_valid = 1; in_sof = 0; in_data = 8'h00; in_par = 0;
        repeat (65535) @(posedge clk);
        @(negedge clk); in_valid = 0;
        rd(3'd2, rv); chk("R6 count before wrap", rv, 16'hFFFF);
        rd(3'd4, rv); chk("R6 not set early", rv, 0);
        @(negedge clk); in_valid = 1;
        @(posedge clk);
        @(negedge clk); in_valid = 0;
        rd(3'd2, rv); chk("R6 count wrapped", rv, 0);
        rd(3'd4, rv); chk("R6 sticky set", rv, 1);
        wr(3'd4, 16'h0000); rd(3'd4, rv); chk("R6 zero write keeps", rv, 1);
        wr(3'd4, 16'h0001); rd(3'd4, rv); chk("R6 cleared by one", rv, 0);

        // R7 loopback
        wr(3'd3, 16'h0001);
        rx_n = 0; out_n = 0;
        send_cell(12'h456, 0); wait_cyc(130);
        chk("R7 looped bytes", out_n, 53);
        chk("R7 rx quiet", rx_n, 0);
        chk("R7 looped content", out_err, 0);
        wr(3'd0, 16'h0FFF); wr(3'd1, 16'h0FFF);
        out_n = 0;
        send_cell(12'h000, 0); wait_cyc(130);
        chk("R7 rejected not looped", out_n, 0);
        wr(3'd1, 16'h0000);

        // R9 flush of transmit buffer
        out_ready = 0;
        send_cell(12'h777, 0); wait_cyc(80);
        wr(3'd3, 16'h0003);
        rd(3'd3, rv); chk("R9 flush bit self-clears", rv, 1);
        out_n = 0; out_ready = 1; wait_cyc(80);
        chk("R9 transmit buffer emptied", out_n, 0);

        // R9 flush of receive buffer
        wr(3'd3, 16'h0000);
        rx_ready = 0;
        send_cell(12'h778, 0); wait_cyc(5);
        wr(3'd3, 16'h0004);
        rd(3'd3, rv); chk("R9 ctrl reads zero", rv, 0);
        rx_n = 0; rx_ready = 1; wait_cyc(80);
        chk("R9 receive buffer emptied", rx_n, 0);

        // R10 back-pressure with two held cells
        rx_ready = 0;
        send_cell(12'h999, 0);
        send_cell(12'h999, 0);
        wait_cyc(3);
        @(negedge clk); chk("R10 stalls with two cells held", in_ready, 0);
        rx_n = 0; rx_err = 0; rx_ready = 1; wait_cyc(130);
        chk("R10 both cells delivered", rx_n, 106);
        chk("R10 content", rx_err, 0);
        @(negedge clk); chk("R10 ready again", in_ready, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule